// File: doc/BRIEF.md
# Flash Wear-Leveling Block Remapper

This block sits between a host that addresses logical blocks and a flash array that is driven as a simple command sink. It holds a logical-to-physical block map, a per-physical-block erase counter, a free-block set and a bad-block set, all in registers. Every host write is redirected to a fresh physical block. Only after the array reports that the program finished does the map move to the new block. The block that used to hold the data is then erased and, unless worn out, returned to the free set.

Blocks whose data never changes would otherwise keep low erase counts while the rest of the array wears. A background relocation moves such cold data onto a heavily worn free block, which puts the lightly worn block back into rotation. Relocation starts only when the wear spread passes a threshold that software sets. It starts only from the idle state and only when no host write is waiting. Physical block 0 is a reserved high-endurance area for controller bookkeeping and is never handed out.

The controller is a four-state machine. The states are IDLE, PROG (program issued for a host write), COPY (relocation copy issued) and ERASE (erase of the vacated block issued). These are its transitions:

- IDLE→PROG when a write is requested and a free block exists.
- IDLE→COPY when no write is requested and the relocation condition holds.
- PROG→ERASE and COPY→ERASE on `cmd_done`.
- ERASE→IDLE on `cmd_done`.

Top module: `wl_remap`

## Requirements
- R1: Reset state:
  - logical block `l` maps to physical block `l+1`;
  - physical block 0 is reserved;
  - physical blocks above `N_LOG` are free;
  - all erase counts are zero;
  - `wear_out` is low, `cmd_valid` is low and `wr_ready` is high.
- R2: An accepted write issues a program command (`cmd_op` = 1). Its `cmd_dst` is the free block with the lowest erase count; among equal counts, the lowest physical index wins.
- R3: The map entry of the written logical block keeps its old physical block until the cycle `cmd_done` completes the program. A read before that returns the old block.
- R4: After a program or copy completes, an erase command (`cmd_op` = 3) is issued with `cmd_dst` set to the vacated block. When that erase completes, the block's erase count rises by one and the block rejoins the free set.
- R5: Physical block 0 never appears as the source or destination of any command.
- R6: Relocation starts when all three of these hold:
  - the highest count among non-bad, non-reserved blocks exceeds the lowest count among mapped blocks by more than `gap_thresh`;
  - a free block exists;
  - that free block's count is above the cold block's count.

  The block then issues a copy (`cmd_op` = 2). Its `cmd_src` is the mapped block with the lowest count (lowest logical index on ties). Its `cmd_dst` is the free block with the highest count (lowest index on ties). The map is updated and the source erased as in R4, and relocation repeats until the condition no longer holds.
- R7: A write request present in IDLE is served before relocation. `wr_ready` stays low while any command sequence is running.
- R8: A block whose erase count reaches `WEAR_LIMIT` on an erase is marked bad and is never again chosen as a destination.
- R9: `wear_out` is high exactly when the free set is empty. While it is high, `wr_ready` stays low, but reads are still served.
- R10: A read request is accepted in any cycle. One cycle later, `rsp_valid` pulses with `rsp_pba` holding the mapped physical block.
- R11: While `cmd_valid` is high and `cmd_done` is low, `cmd_valid`, `cmd_op`, `cmd_src` and `cmd_dst` hold their values into the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_write | input | 1 | 1 = write request, 0 = address read |
| req_lba | input | LW | Logical block of the request |
| wr_ready | output | 1 | A write request is accepted on this edge |
| rsp_valid | output | 1 | Read response valid |
| rsp_pba | output | PW | Physical block mapped to the read logical block |
| gap_thresh | input | CW | Wear spread above which relocation runs |
| cmd_valid | output | 1 | Command to the array is pending |
| cmd_op | output | 2 | 1 program, 2 copy, 3 erase |
| cmd_src | output | PW | Copy source block (0 for other commands) |
| cmd_dst | output | PW | Target block of the command |
| cmd_done | input | 1 | Array completed the pending command |
| wear_out | output | 1 | No free physical block remains |

## Verification
The hardest situation to reach from the ports is a relocation decision. It needs a specific wear spread between mapped and free blocks, and it needs to collide in the same cycle with a host write. The bench first levels the free pool by rewriting one logical block several times while leaving three others untouched, so the untouched ones become cold. It then lowers `gap_thresh` in the very cycle it raises a write request, which exercises the write-first priority. After that it follows the whole relocation chain with a reference model of the selection rules. A small `WEAR_LIMIT` is used so that repeated writes drive blocks bad until the free set is empty.

// File: rtl/wl_pkg.sv
package wl_pkg;

    // Command encoding seen by the flash array
    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_PROG  = 2'd1,
        OP_COPY  = 2'd2,
        OP_ERASE = 2'd3
    } wl_op_e;

    // Controller states
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PROG,
        ST_COPY,
        ST_ERASE
    } wl_state_e;

    // Physical block kept for controller bookkeeping
    localparam int RSV_PBA = 0;

endpackage

// File: rtl/wl_pick.sv
// Linear scan over N keyed entries: returns the index of the smallest
// (or largest) valid key, lowest index winning ties.
module wl_pick #(
    parameter int N        = 8,
    parameter int KW       = 8,
    parameter bit FIND_MAX = 1'b0,
    localparam int IW      = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0][KW-1:0] key,
    input  logic [N-1:0]         vld,
    output logic                 found,
    output logic [IW-1:0]        idx
);

    logic [KW-1:0] best;

    generate
        if (FIND_MAX) begin : g_max
            always_comb begin
                found = 1'b0;
                idx   = '0;
                best  = '0;
                for (int i = 0; i < N; i++) begin
                    if (vld[i] && (!found || key[i] > best)) begin
                        found = 1'b1;
                        idx   = IW'(i);
                        best  = key[i];
                    end
                end
            end
        end else begin : g_min
            always_comb begin
                found = 1'b0;
                idx   = '0;
                best  = '0;
                for (int i = 0; i < N; i++) begin
                    if (vld[i] && (!found || key[i] < best)) begin
                        found = 1'b1;
                        idx   = IW'(i);
                        best  = key[i];
                    end
                end
            end
        end
    endgenerate

endmodule

// File: rtl/wl_table.sv
// Map, erase counters, free set and bad set.
module wl_table #(
    parameter int N_LOG      = 4,
    parameter int N_PHYS     = 8,
    parameter int CW         = 17,
    parameter int WEAR_LIMIT = 100000,
    localparam int LW        = $clog2(N_LOG),
    localparam int PW        = $clog2(N_PHYS)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         map_we,
    input  logic [LW-1:0]                map_lba,
    input  logic [PW-1:0]                map_pba,
    input  logic                         ers_we,
    input  logic [PW-1:0]                ers_pba,
    output logic [N_LOG-1:0][PW-1:0]     map_q,
    output logic [N_PHYS-1:0][CW-1:0]    cnt_q,
    output logic [N_PHYS-1:0]            free_q,
    output logic [N_PHYS-1:0]            bad_q
);

    logic [CW:0] ers_next;
    logic        wear_hit;

    always_comb begin
        ers_next = {1'b0, cnt_q[ers_pba]} + 1'b1;
        wear_hit = (ers_next >= (CW+1)'(WEAR_LIMIT));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int l = 0; l < N_LOG; l++) begin
                map_q[l] <= PW'(l + 1);
            end
            for (int p = 0; p < N_PHYS; p++) begin
                cnt_q[p]  <= '0;
                free_q[p] <= (p > N_LOG);
                bad_q[p]  <= 1'b0;
            end
        end else begin
            if (map_we) begin
                map_q[map_lba]  <= map_pba;
                free_q[map_pba] <= 1'b0;
            end
            if (ers_we) begin
                cnt_q[ers_pba] <= ers_next[CW-1:0];
                if (wear_hit) begin
                    bad_q[ers_pba] <= 1'b1;
                end else begin
                    free_q[ers_pba] <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/wl_ctrl.sv
// Command sequencer: IDLE -> PROG|COPY -> ERASE -> IDLE
module wl_ctrl
    import wl_pkg::*;
#(
    parameter int LW = 2,
    parameter int PW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_req,
    input  logic [LW-1:0] req_lba,
    input  logic [PW-1:0] req_old_pba,
    input  logic          have_free,
    input  logic [PW-1:0] low_free_pba,
    input  logic          reloc_go,
    input  logic [LW-1:0] cold_lba,
    input  logic [PW-1:0] cold_pba,
    input  logic [PW-1:0] hot_free_pba,
    input  logic          cmd_done,
    output logic          wr_ready,
    output logic          cmd_valid,
    output logic [1:0]    cmd_op,
    output logic [PW-1:0] cmd_src,
    output logic [PW-1:0] cmd_dst,
    output logic          map_we,
    output logic [LW-1:0] map_lba,
    output logic [PW-1:0] map_pba,
    output logic          ers_we,
    output logic [PW-1:0] ers_pba
);

    wl_state_e     state_q, state_d;
    logic [LW-1:0] lba_q;
    logic [PW-1:0] tgt_q;
    logic [PW-1:0] old_q;
    logic          take_wr;
    logic          take_reloc;

    always_comb begin
        take_wr    = (state_q == ST_IDLE) && wr_req && have_free;
        take_reloc = (state_q == ST_IDLE) && !wr_req && reloc_go;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // operation context captured on leaving IDLE
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lba_q <= '0;
            tgt_q <= '0;
            old_q <= '0;
        end else if (take_wr) begin
            lba_q <= req_lba;
            tgt_q <= low_free_pba;
            old_q <= req_old_pba;
        end else if (take_reloc) begin
            lba_q <= cold_lba;
            tgt_q <= hot_free_pba;
            old_q <= cold_pba;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (take_wr) begin
                    state_d = ST_PROG;
                end else if (take_reloc) begin
                    state_d = ST_COPY;
                end
            end
            ST_PROG: begin
                if (cmd_done) state_d = ST_ERASE;
            end
            ST_COPY: begin
                if (cmd_done) state_d = ST_ERASE;
            end
            ST_ERASE: begin
                if (cmd_done) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        wr_ready  = 1'b0;
        cmd_valid = 1'b0;
        cmd_op    = OP_NONE;
        cmd_src   = '0;
        cmd_dst   = '0;
        map_we    = 1'b0;
        ers_we    = 1'b0;
        map_lba   = lba_q;
        map_pba   = tgt_q;
        ers_pba   = old_q;
        unique case (state_q)
            ST_IDLE: begin
                wr_ready = have_free;
            end
            ST_PROG: begin
                cmd_valid = 1'b1;
                cmd_op    = OP_PROG;
                cmd_dst   = tgt_q;
                map_we    = cmd_done;
            end
            ST_COPY: begin
                cmd_valid = 1'b1;
                cmd_op    = OP_COPY;
                cmd_src   = old_q;
                cmd_dst   = tgt_q;
                map_we    = cmd_done;
            end
            ST_ERASE: begin
                cmd_valid = 1'b1;
                cmd_op    = OP_ERASE;
                cmd_dst   = old_q;
                ers_we    = cmd_done;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/wl_remap.sv
module wl_remap
    import wl_pkg::*;
#(
    parameter int N_LOG      = 4,
    parameter int N_PHYS     = 8,
    parameter int CW         = 17,
    parameter int WEAR_LIMIT = 100000,
    localparam int LW        = $clog2(N_LOG),
    localparam int PW        = $clog2(N_PHYS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic [LW-1:0] req_lba,
    output logic          wr_ready,
    output logic          rsp_valid,
    output logic [PW-1:0] rsp_pba,
    input  logic [CW-1:0] gap_thresh,
    output logic          cmd_valid,
    output logic [1:0]    cmd_op,
    output logic [PW-1:0] cmd_src,
    output logic [PW-1:0] cmd_dst,
    input  logic          cmd_done,
    output logic          wear_out
);

    logic [N_LOG-1:0][PW-1:0]  map_q;
    logic [N_PHYS-1:0][CW-1:0] cnt_q;
    logic [N_PHYS-1:0]         free_q;
    logic [N_PHYS-1:0]         bad_q;
    logic [N_PHYS-1:0]         good_vld;
    logic [N_LOG-1:0][CW-1:0]  used_key;

    logic          map_we, ers_we;
    logic [LW-1:0] map_lba;
    logic [PW-1:0] map_pba, ers_pba;

    logic          low_free_found, hot_free_found, hot_good_found, cold_found;
    logic [PW-1:0] low_free_pba, hot_free_pba, hot_good_pba;
    logic [LW-1:0] cold_lba;
    logic [PW-1:0] cold_pba, req_old_pba;
    logic [CW-1:0] cold_cnt, hot_good_cnt, hot_free_cnt;
    logic          reloc_go;
    logic          wr_req;

    wl_table #(
        .N_LOG      (N_LOG),
        .N_PHYS     (N_PHYS),
        .CW         (CW),
        .WEAR_LIMIT (WEAR_LIMIT)
    ) u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .map_we  (map_we),
        .map_lba (map_lba),
        .map_pba (map_pba),
        .ers_we  (ers_we),
        .ers_pba (ers_pba),
        .map_q   (map_q),
        .cnt_q   (cnt_q),
        .free_q  (free_q),
        .bad_q   (bad_q)
    );

    // candidate sets
    always_comb begin
        good_vld          = ~bad_q;
        good_vld[RSV_PBA] = 1'b0;
        for (int l = 0; l < N_LOG; l++) begin
            used_key[l] = cnt_q[map_q[l]];
        end
    end

    wl_pick #(.N(N_PHYS), .KW(CW), .FIND_MAX(1'b0)) u_low_free (
        .key (cnt_q), .vld (free_q), .found (low_free_found), .idx (low_free_pba)
    );

    wl_pick #(.N(N_PHYS), .KW(CW), .FIND_MAX(1'b1)) u_hot_free (
        .key (cnt_q), .vld (free_q), .found (hot_free_found), .idx (hot_free_pba)
    );

    wl_pick #(.N(N_PHYS), .KW(CW), .FIND_MAX(1'b1)) u_hot_good (
        .key (cnt_q), .vld (good_vld), .found (hot_good_found), .idx (hot_good_pba)
    );

    wl_pick #(.N(N_LOG), .KW(CW), .FIND_MAX(1'b0)) u_cold (
        .key (used_key), .vld ({N_LOG{1'b1}}), .found (cold_found), .idx (cold_lba)
    );

    // relocation decision
    always_comb begin
        cold_pba     = map_q[cold_lba];
        cold_cnt     = cnt_q[cold_pba];
        hot_good_cnt = cnt_q[hot_good_pba];
        hot_free_cnt = cnt_q[hot_free_pba];
        req_old_pba  = map_q[req_lba];
        reloc_go     = cold_found && hot_good_found && hot_free_found
                       && (hot_good_cnt > cold_cnt)
                       && ((hot_good_cnt - cold_cnt) > gap_thresh)
                       && (hot_free_cnt > cold_cnt);
        wr_req       = req_valid && req_write;
        wear_out     = !low_free_found;
    end

    wl_ctrl #(.LW(LW), .PW(PW)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_req       (wr_req),
        .req_lba      (req_lba),
        .req_old_pba  (req_old_pba),
        .have_free    (low_free_found),
        .low_free_pba (low_free_pba),
        .reloc_go     (reloc_go),
        .cold_lba     (cold_lba),
        .cold_pba     (cold_pba),
        .hot_free_pba (hot_free_pba),
        .cmd_done     (cmd_done),
        .wr_ready     (wr_ready),
        .cmd_valid    (cmd_valid),
        .cmd_op       (cmd_op),
        .cmd_src      (cmd_src),
        .cmd_dst      (cmd_dst),
        .map_we       (map_we),
        .map_lba      (map_lba),
        .map_pba      (map_pba),
        .ers_we       (ers_we),
        .ers_pba      (ers_pba)
    );

    // address read path
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_pba   <= '0;
        end else begin
            rsp_valid <= req_valid && !req_write;
            rsp_pba   <= map_q[req_lba];
        end
    end

endmodule

// File: rtl/wl_remap_chk.sv
module wl_remap_chk #(
    parameter int PW = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          req_write,
    input logic          wr_ready,
    input logic          rsp_valid,
    input logic          cmd_valid,
    input logic [1:0]    cmd_op,
    input logic [PW-1:0] cmd_src,
    input logic [PW-1:0] cmd_dst,
    input logic          cmd_done,
    input logic          wear_out
);

    AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !cmd_done |=> cmd_valid && $stable(cmd_op) && $stable(cmd_src) && $stable(cmd_dst)); // R11

    AST_NO_RSV_DST: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> cmd_dst != '0); // R5

    AST_NO_RSV_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_op == 2'd2 |-> cmd_src != '0); // R5

    AST_ERASE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_done && (cmd_op == 2'd1 || cmd_op == 2'd2) |=> cmd_valid && cmd_op == 2'd3); // R4

    AST_COPY_DISTINCT: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_op == 2'd2 |-> cmd_src != cmd_dst); // R6

    AST_READ_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_write |=> rsp_valid); // R10

    AST_BUSY_NO_WR: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> !wr_ready); // R7

    AST_WEAR_NO_WR: assert property (@(posedge clk) disable iff (!rst_n)
        wear_out |-> !wr_ready); // R9

endmodule

bind wl_remap wl_remap_chk #(.PW(PW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .wr_ready  (wr_ready),
    .rsp_valid (rsp_valid),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_src   (cmd_src),
    .cmd_dst   (cmd_dst),
    .cmd_done  (cmd_done),
    .wear_out  (wear_out)
);

// File: tb/sim_wl_remap.sv
module sim_wl_remap;

    localparam int CLK_PERIOD = 10;
    localparam int NL    = 4;
    localparam int NP    = 8;
    localparam int CWB   = 8;
    localparam int LIMIT = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0, req_write = 1'b0;
    logic [1:0] req_lba = '0;
    logic       wr_ready, rsp_valid, cmd_valid, wear_out;
    logic [2:0] rsp_pba, cmd_src, cmd_dst;
    logic [1:0] cmd_op;
    logic [7:0] gap_thresh = 8'd255;
    logic       cmd_done = 1'b0;

    int n_tests = 0;
    int n_fail  = 0;

    // reference model
    int m_map[NL];
    int m_cnt[NP];
    bit m_free[NP];
    bit m_bad[NP];

    always #(CLK_PERIOD/2) clk = ~clk;

    wl_remap #(.N_LOG(NL), .N_PHYS(NP), .CW(CWB), .WEAR_LIMIT(LIMIT)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_lba(req_lba), .wr_ready(wr_ready), .rsp_valid(rsp_valid), .rsp_pba(rsp_pba),
        .gap_thresh(gap_thresh), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_src(cmd_src), .cmd_dst(cmd_dst), .cmd_done(cmd_done), .wear_out(wear_out)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int m_min_free();
        int b = -1;
        for (int p = 0; p < NP; p++)
            if (m_free[p] && (b < 0 || m_cnt[p] < m_cnt[b])) b = p;
        return b;
    endfunction

    function automatic int m_hot_free();
        int b = -1;
        for (int p = 0; p < NP; p++)
            if (m_free[p] && (b < 0 || m_cnt[p] > m_cnt[b])) b = p;
        return b;
    endfunction

    function automatic int m_cold_lba();
        int b = 0;
        for (int l = 1; l < NL; l++)
            if (m_cnt[m_map[l]] < m_cnt[m_map[b]]) b = l;
        return b;
    endfunction

    function automatic bit m_trig(input int th);
        int hg = 0;
        int hf = m_hot_free();
        int cc = m_cnt[m_map[m_cold_lba()]];
        for (int p = 1; p < NP; p++)
            if (!m_bad[p] && m_cnt[p] > hg) hg = m_cnt[p];
        if (hf < 0) return 1'b0;
        return (hg - cc > th) && (m_cnt[hf] > cc);
    endfunction

    task automatic m_erase(input int p);
        m_cnt[p]++;
        if (m_cnt[p] >= LIMIT) m_bad[p] = 1'b1;
        else m_free[p] = 1'b1;
    endtask

    task automatic do_read(input int lba, input int exp, input string req);
        req_valid = 1'b1; req_write = 1'b0; req_lba = 2'(lba);
        @(negedge clk);
        req_valid = 1'b0;
        chk(rsp_valid == 1'b1, req, rsp_valid, 1);
        chk(int'(rsp_pba) == exp, req, rsp_pba, exp);
    endtask

    task automatic do_write(input int lba);
        int dst = m_min_free();
        int old = m_map[lba];
        chk(wear_out == (dst < 0), "R9", wear_out, dst < 0);
        req_valid = 1'b1; req_write = 1'b1; req_lba = 2'(lba);
        for (int i = 0; i < 50 && !wr_ready; i++) @(negedge clk);
        chk(wr_ready == 1'b1, "R7", wr_ready, 1);
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        chk(cmd_valid && cmd_op == 2'd1, "R2", cmd_op, 1);
        chk(int'(cmd_dst) == dst, "R2", cmd_dst, dst);
        // mapping must still point to the old block (R3)
        do_read(lba, old, "R3");
        chk(cmd_valid && cmd_op == 2'd1 && int'(cmd_dst) == dst, "R11", cmd_dst, dst);
        cmd_done = 1'b1; @(negedge clk); cmd_done = 1'b0;
        chk(cmd_valid && cmd_op == 2'd3, "R4", cmd_op, 3);
        chk(int'(cmd_dst) == old, "R4", cmd_dst, old);
        cmd_done = 1'b1; @(negedge clk); cmd_done = 1'b0;
        m_map[lba] = dst; m_free[dst] = 1'b0;
        m_erase(old);
    endtask

    task automatic do_reloc();
        int cl  = m_cold_lba();
        int src = m_map[cl];
        int dst = m_hot_free();
        for (int i = 0; i < 20 && !cmd_valid; i++) @(negedge clk);
        chk(cmd_valid && cmd_op == 2'd2, "R6", cmd_op, 2);
        chk(int'(cmd_src) == src, "R6", cmd_src, src);
        chk(int'(cmd_dst) == dst, "R6", cmd_dst, dst);
        // a write requested mid-sequence must wait (R7)
        req_valid = 1'b1; req_write = 1'b1; req_lba = 2'd1;
        chk(wr_ready == 1'b0, "R7", wr_ready, 0);
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        chk(cmd_valid && cmd_op == 2'd2, "R7", cmd_op, 2);
        cmd_done = 1'b1; @(negedge clk); cmd_done = 1'b0;
        chk(cmd_valid && cmd_op == 2'd3 && int'(cmd_dst) == src, "R4", cmd_dst, src);
        cmd_done = 1'b1; @(negedge clk); cmd_done = 1'b0;
        m_map[cl] = dst; m_free[dst] = 1'b0;
        m_erase(src);
    endtask

    task automatic t_reset();
        for (int l = 0; l < NL; l++) m_map[l] = l + 1;
        for (int p = 0; p < NP; p++) begin
            m_cnt[p] = 0; m_bad[p] = 1'b0; m_free[p] = (p > NL);
        end
        chk(cmd_valid == 1'b0, "R1", cmd_valid, 0);
        chk(wear_out == 1'b0, "R1", wear_out, 0);
        chk(wr_ready == 1'b1, "R1", wr_ready, 1);
        for (int l = 0; l < NL; l++) do_read(l, l + 1, "R1");
        do_read(2, 3, "R10");
    endtask

    task automatic t_dynamic();
        for (int l = 0; l < NL; l++) do_write(l);
        // fourth write reuses block 1: all free counts equal, lowest index (R2)
        do_read(3, 1, "R2");
        for (int i = 0; i < 4; i++) do_write(3);
        for (int l = 0; l < NL; l++) do_read(l, m_map[l], "R4");
    endtask

    task automatic t_reloc();
        int guard = 0;
        chk(m_trig(1), "R6", 0, 1);
        // threshold drops in the same cycle as a write request (R7)
        gap_thresh = 8'd1;
        do_write(3);
        while (m_trig(1) && guard < 20) begin
            do_reloc();
            guard++;
        end
        chk(guard > 0, "R6", guard, 1);
        for (int i = 0; i < 10; i++) @(negedge clk);
        chk(cmd_valid == 1'b0, "R6", cmd_valid, 0);
        for (int l = 0; l < NL; l++) do_read(l, m_map[l], "R6");
        gap_thresh = 8'd255;
        @(negedge clk);
    endtask

    task automatic t_wear();
        int n_bad = 0;
        for (int i = 0; i < 80 && m_min_free() >= 0; i++) do_write(0);
        for (int p = 0; p < NP; p++) n_bad += m_bad[p];
        chk(n_bad > 0, "R8", n_bad, 1);
        chk(wear_out == 1'b1, "R9", wear_out, 1);
        req_valid = 1'b1; req_write = 1'b1; req_lba = 2'd2;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk(wr_ready == 1'b0 && cmd_valid == 1'b0, "R9", cmd_valid, 0);
        end
        req_valid = 1'b0; req_write = 1'b0;
        do_read(0, m_map[0], "R9");
        chk(m_bad[m_map[0]] == 1'b0, "R8", m_bad[m_map[0]], 0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_dynamic();
        t_reloc();
        t_wear();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule